// File: doc/BRIEF.md
# Square-Root Carry Select Adder

A purely combinational adder that forms `a_i + b_i + carry_i`. The operand is cut into groups whose widths grow towards the most significant end. The lowest group is a plain ripple adder fed by the external carry. Every higher group prepares two results ahead of time, one for an incoming carry of 0 and one for an incoming carry of 1. The carry that leaves the group below then picks one of them. Because later groups are wider and their carry arrives later, the time each group spends building its two candidates roughly matches the time its selecting carry takes to arrive.

The parameter `MODE` chooses how a group builds its carry-in-of-1 candidate:
- **Mode 0** uses a second ripple adder with its carry tied high.
- **Mode 1** feeds the carry-in-of-0 result, carry bit included, through an incrementer. The incrementer flips each bit when all the bits below it are ones.
- **Mode 2** shares logic per bit. The carry-in-of-1 sum is the inverse of the carry-in-of-0 sum, and the carry pair is (A AND B, A OR B). The real carry then steps through each bit's 2:1 selector.

`WIDTH` selects one of three layouts:
- **16 bits**: five groups.
- **8 bits**: the lowest three groups, then one full adder for bit 7.
- **Any multiple of 16**: a cascade of 16-bit sections, where each section's carry-out is the next section's carry-in.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, `{carry_o, sum_o}` equals the (WIDTH+1)-bit value `a_i + b_i + carry_i`.
- R2: In a 16-bit section, the groups from the least significant end are 2, 2, 3, 4 and 5 bits wide (bits 0-1, 2-3, 4-6, 7-10, 11-15). A carry that starts below bit 2, 4, 7, 11 or 16 reaches past that boundary correctly.
- R3: The lowest group ripples from `carry_i`. With both operands zero, `carry_i` = 1 gives `sum_o` = 1.
- R4: `MODE` = 0 (a duplicate ripple adder with carry 1 in each selected group) meets R1.
- R5: `MODE` = 1 (an excess-one incrementer over the carry-in-of-0 result and its carry) meets R1.
- R6: `MODE` = 2 (shared per-bit logic: inverted sum, and OR versus AND for the carry) meets R1.
- R7: `WIDTH` = 8 uses groups of 2, 2 and 3 bits, plus one full adder for bit 7. It meets R1 for all 2^17 input combinations.
- R8: `WIDTH` = 32 chains two 16-bit sections. The carry from bit 15 enters bit 16, so `a_i` = 0x0000FFFF, `b_i` = 0, `carry_i` = 1 gives 0x00010000.
- R9: `carry_o` is the selected carry of the top group. An all-ones operand plus 0 plus `carry_i` = 1 wraps `sum_o` to zero with `carry_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Incoming carry |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top group |

## Verification
In a single evaluation, the carry rippling inside the lowest group and the selection of a precomputed result in every higher group both have to resolve. The bench provokes this with operands of the form 2^k - 1 plus one at every group boundary, and with all-ones operands, so that the selecting carry toggles in the same step that the lower ripple settles. All three construction modes see the same stimulus at once. Each result is judged against an arithmetic sum formed in the bench, including the carry bit.

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int WIDTH = 16,
  parameter int MODE  = 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int SECTIONS = (WIDTH == 8) ? 1 : WIDTH / 16;
  localparam int NGRP     = (WIDTH == 8) ? 4 : 5 * SECTIONS;

  function automatic int grp_lo(input int g);
    int off;
    if (WIDTH == 8) begin
      case (g)
        0: off = 0;
        1: off = 2;
        2: off = 4;
        default: off = 7;
      endcase
      return off;
    end
    case (g % 5)
      0: off = 0;
      1: off = 2;
      2: off = 4;
      3: off = 7;
      default: off = 11;
    endcase
    return 16 * (g / 5) + off;
  endfunction

  function automatic int grp_w(input int g);
    if (WIDTH == 8) begin
      case (g)
        0, 1: return 2;
        2: return 3;
        default: return 1;
      endcase
    end
    case (g % 5)
      0, 1: return 2;
      2: return 3;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic bit grp_plain(input int g);
    if (WIDTH == 8) return (g == 0) || (g == 3);
    return (g % 5) == 0;
  endfunction

  logic [NGRP:0] gc;
  assign gc[0]   = carry_i;
  assign carry_o = gc[NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int W  = grp_w(g);
    localparam bit PL = grp_plain(g);

    logic [W-1:0] ga, gb, gsum;
    logic         gco;

    assign ga = a_i[LO +: W];
    assign gb = b_i[LO +: W];
    assign sum_o[LO +: W] = gsum;
    assign gc[g+1] = gco;

    if (PL) begin : g_plain
      always_comb begin : p_rip
        logic c;
        c = gc[g];
        for (int i = 0; i < W; i++) begin
          gsum[i] = ga[i] ^ gb[i] ^ c;
          c = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
        end
        gco = c;
      end
    end else if (MODE == 2) begin : g_shared
      always_comb begin : p_shr
        logic c, p, cp0, cp1;
        c = gc[g];
        for (int i = 0; i < W; i++) begin
          p   = ga[i] ^ gb[i];
          cp0 = ga[i] & gb[i];
          cp1 = ga[i] | gb[i];
          gsum[i] = c ? ~p : p;
          c = c ? cp1 : cp0;
        end
        gco = c;
      end

      always_comb begin : p_chk_bit
        logic c, nx;
        c = gc[g];
        for (int i = 0; i < W; i++) begin
          nx = (i == W - 1) ? gco : 1'b0;
          if (i < W - 1) nx = (ga[i+1] ^ gb[i+1]) ^ gsum[i+1];
          // R6: carry entering the next bit is the majority of a, b and carry
          assert_shared_carry_R6: assert (nx == ((ga[i] & gb[i]) | (ga[i] & c) | (gb[i] & c)))
            else $error("shared carry mismatch group %0d bit %0d", g, i);
          c = nx;
        end
      end
    end else begin : g_select
      logic [W-1:0] s0, s1;
      logic         co0, co1;

      always_comb begin : p_rip0
        logic c;
        c = 1'b0;
        for (int i = 0; i < W; i++) begin
          s0[i] = ga[i] ^ gb[i] ^ c;
          c = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
        end
        co0 = c;
      end

      if (MODE == 0) begin : g_dup
        always_comb begin : p_rip1
          logic c;
          c = 1'b1;
          for (int i = 0; i < W; i++) begin
            s1[i] = ga[i] ^ gb[i] ^ c;
            c = (ga[i] & gb[i]) | (c & (ga[i] ^ gb[i]));
          end
          co1 = c;
        end
      end else begin : g_exc
        always_comb begin : p_inc
          logic [W:0] r, x;
          logic run;
          r   = {co0, s0};
          run = 1'b1;
          for (int i = 0; i <= W; i++) begin
            x[i] = r[i] ^ run;
            run  = run & r[i];
          end
          s1  = x[W-1:0];
          co1 = x[W];
        end
      end

      assign gsum = gc[g] ? s1 : s0;
      assign gco  = gc[g] ? co1 : co0;

      always_comb begin
        // R4 / R5: carry-in-of-1 candidate is the carry-in-of-0 candidate plus one
        assert_alt_plus_one_R5: assert ({co1, s1} == {co0, s0} + (W+1)'(1))
          else $error("carry-1 candidate wrong in group %0d", g);
      end
    end

    always_comb begin
      // R2: every group adds its slice with its incoming carry
      assert_group_sum_R2: assert ({gco, gsum} == (W+1)'(ga) + (W+1)'(gb) + (W+1)'(gc[g]))
        else $error("group %0d sum mismatch", g);
    end
  end

  always_comb begin
    // R1 / R9: whole result including the top carry
    assert_total_R1: assert ({carry_o, sum_o} == (WIDTH+1)'(a_i) + (WIDTH+1)'(b_i) + (WIDTH+1)'(carry_i))
      else $error("total sum mismatch");
  end

endmodule

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  a8,  b8;
  logic [15:0] a16, b16;
  logic [31:0] a32, b32;
  logic        ci;

  logic [7:0]  s8  [3];
  logic [15:0] s16 [3];
  logic [31:0] s32 [3];
  logic        c8  [3];
  logic        c16 [3];
  logic        c32 [3];

  sqrt_csel_adder #(.WIDTH(16), .MODE(2)) u_sqrt_csel_adder (
    .a_i(a16), .b_i(b16), .carry_i(ci), .sum_o(s16[2]), .carry_o(c16[2]));
  sqrt_csel_adder #(.WIDTH(16), .MODE(0)) u_w16_m0 (
    .a_i(a16), .b_i(b16), .carry_i(ci), .sum_o(s16[0]), .carry_o(c16[0]));
  sqrt_csel_adder #(.WIDTH(16), .MODE(1)) u_w16_m1 (
    .a_i(a16), .b_i(b16), .carry_i(ci), .sum_o(s16[1]), .carry_o(c16[1]));
  sqrt_csel_adder #(.WIDTH(8), .MODE(0)) u_w8_m0 (
    .a_i(a8), .b_i(b8), .carry_i(ci), .sum_o(s8[0]), .carry_o(c8[0]));
  sqrt_csel_adder #(.WIDTH(8), .MODE(1)) u_w8_m1 (
    .a_i(a8), .b_i(b8), .carry_i(ci), .sum_o(s8[1]), .carry_o(c8[1]));
  sqrt_csel_adder #(.WIDTH(8), .MODE(2)) u_w8_m2 (
    .a_i(a8), .b_i(b8), .carry_i(ci), .sum_o(s8[2]), .carry_o(c8[2]));
  sqrt_csel_adder #(.WIDTH(32), .MODE(0)) u_w32_m0 (
    .a_i(a32), .b_i(b32), .carry_i(ci), .sum_o(s32[0]), .carry_o(c32[0]));
  sqrt_csel_adder #(.WIDTH(32), .MODE(1)) u_w32_m1 (
    .a_i(a32), .b_i(b32), .carry_i(ci), .sum_o(s32[1]), .carry_o(c32[1]));
  sqrt_csel_adder #(.WIDTH(32), .MODE(2)) u_w32_m2 (
    .a_i(a32), .b_i(b32), .carry_i(ci), .sum_o(s32[2]), .carry_o(c32[2]));

  function automatic string mtag(input int m);
    return (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
  endfunction

  task automatic add8(input logic [7:0] a, input logic [7:0] b, input logic c, input string req);
    logic [8:0] exp;
    a8 = a; b8 = b; ci = c;
    #1;
    exp = 9'(a) + 9'(b) + 9'(c);
    for (int m = 0; m < 3; m++) begin
      checks++;
      if ({c8[m], s8[m]} !== exp) begin
        errors++;
        $display("FAIL %s/%s w8 a=%h b=%h ci=%b actual=%h expected=%h", req, mtag(m), a, b, c, {c8[m], s8[m]}, exp);
      end
    end
  endtask

  task automatic add16(input logic [15:0] a, input logic [15:0] b, input logic c, input string req);
    logic [16:0] exp;
    a16 = a; b16 = b; ci = c;
    #1;
    exp = 17'(a) + 17'(b) + 17'(c);
    for (int m = 0; m < 3; m++) begin
      checks++;
      if ({c16[m], s16[m]} !== exp) begin
        errors++;
        $display("FAIL %s/%s w16 a=%h b=%h ci=%b actual=%h expected=%h", req, mtag(m), a, b, c, {c16[m], s16[m]}, exp);
      end
    end
  endtask

  task automatic add32(input logic [31:0] a, input logic [31:0] b, input logic c, input string req);
    logic [32:0] exp;
    a32 = a; b32 = b; ci = c;
    #1;
    exp = 33'(a) + 33'(b) + 33'(c);
    for (int m = 0; m < 3; m++) begin
      checks++;
      if ({c32[m], s32[m]} !== exp) begin
        errors++;
        $display("FAIL %s/%s w32 a=%h b=%h ci=%b actual=%h expected=%h", req, mtag(m), a, b, c, {c32[m], s32[m]}, exp);
      end
    end
  endtask

  task automatic t_reset;
    add8(8'h00, 8'h00, 1'b0, "R1");
    add16(16'h0000, 16'h0000, 1'b0, "R1");
    add32(32'h0, 32'h0, 1'b0, "R1");
  endtask

  task automatic t_lowest_carry;
    add16(16'h0000, 16'h0000, 1'b1, "R3");
    add16(16'h0001, 16'h0000, 1'b1, "R3");
    add8(8'h03, 8'h00, 1'b1, "R3");
  endtask

  task automatic t_boundaries;
    int edges [5] = '{2, 4, 7, 11, 16};
    for (int k = 0; k < 5; k++) begin
      logic [16:0] ones;
      ones = (17'd1 << edges[k]) - 17'd1;
      add16(ones[15:0], 16'h0001, 1'b0, "R2");
      add16(ones[15:0], 16'h0000, 1'b1, "R2");
      add16(16'(17'd1 << (edges[k] - 1)), 16'(17'd1 << (edges[k] - 1)), 1'b0, "R2");
      add16(16'(17'd1 << (edges[k] - 1)), 16'(17'd1 << (edges[k] - 1)), 1'b1, "R2");
    end
  endtask

  task automatic t_wrap;
    add16(16'hFFFF, 16'h0000, 1'b1, "R9");
    add16(16'hFFFF, 16'hFFFF, 1'b1, "R9");
    add16(16'h8000, 16'h8000, 1'b0, "R9");
    add8(8'hFF, 8'h00, 1'b1, "R9");
    add32(32'hFFFF_FFFF, 32'h0, 1'b1, "R9");
  endtask

  task automatic t_cascade;
    add32(32'h0000_FFFF, 32'h0, 1'b1, "R8");
    add32(32'h0000_8000, 32'h0000_8000, 1'b0, "R8");
    add32(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R8");
    add32(32'hFFFF_0000, 32'h0001_0000, 1'b0, "R8");
  endtask

  task automatic t_exhaustive8;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          add8(8'(a), 8'(b), 1'(c), "R7");
  endtask

  task automatic t_random;
    for (int n = 0; n < 3000; n++) begin
      add16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
      add32($urandom, $urandom, 1'($urandom), "R1");
    end
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0; ci = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lowest_carry();
    t_boundaries();
    t_wrap();
    t_cascade();
    t_exhaustive8();
    t_random();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=complete");
      finish_run();
    end
  end

endmodule